// File: doc/BRIEF.md
# Five-Source Interrupt Gate Register

This block merges five single-cycle interrupt request pulses into one host interrupt line. The sources are synchronous serial, asynchronous serial, timer 2, timer 1 and external. Each pulse sets a sticky pending latch for its source. A 16-bit control word decides which pending requests reach the host line.

The host writes the full 16-bit word in one cycle. The low byte holds the enable bits, which are stored and can be read back. The high byte holds write-one-to-clear bits that drop the matching pending latches. The register is split: the high byte of a read returns the live pending latches, not the clear bits that were written.

The register port is a plain control interface with a write strobe and a combinational read word. It carries no stream traffic, so it has no valid/ready handshake and no back-pressure. Every write is accepted in the cycle its strobe is high.

Top module: `ige_ctrl`

## Requirements
- R1: After reset all enables and all pending latches are zero, so `rd_data` reads 0x0000 and `irq_out` is low.
- R2: A write stores `wr_data[4:0]` as the five enables, which read back on `rd_data[4:0]` from the cycle after the write. The bit order is external=0, timer 1=1, timer 2=2, asynchronous serial=3, synchronous serial=4.
- R3: A one on `req_pulse[i]` sets pending latch i, which is visible on `rd_data[8+i]` from the next cycle. The source order is the same as in R2.
- R4: A set pending latch stays set until a write with `wr_data[8+i]`=1. A write with that bit at 0 leaves it unchanged.
- R5: When `req_pulse[i]` and a clear of source i fall in the same cycle, the latch ends up set.
- R6: `irq_out` is high exactly when some source is both pending and enabled.
- R7: Bits 15..13 and 7..5 of `rd_data` always read zero, and writing ones to them changes nothing.
- R8: A source latches its pending request even while disabled. Enabling it later raises `irq_out` with no new pulse.
- R9: The enable byte and the clear byte of one write act independently. Enables are replaced on every write, and clear bits never alter enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pulse | input | 5 | Single-cycle request pulse per source |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Written word: enables in [4:0], clears in [12:8] |
| rd_data | output | 16 | Enables in [4:0], pending latches in [12:8] |
| irq_out | output | 1 | Combined host interrupt |

## Verification
The hardest case to reach from the ports is a request pulse that lands in the same cycle as a write clearing that source, with the enable state changing in the same write. Random stimulus drives pulses and clear masks often enough that these collisions occur many times. Directed steps also force the collision on every source at once and on a single source alone. A reference model that gives priority to the set pulse checks each outcome.

// File: rtl/ige_pkg.sv
package ige_pkg;
  localparam int NSRC    = 5;
  localparam int WORD_W  = 16;
  localparam int CLR_LSB = 8;

  typedef enum logic [2:0] {
    SRC_EXT   = 3'd0,
    SRC_TMR1  = 3'd1,
    SRC_TMR2  = 3'd2,
    SRC_ASER  = 3'd3,
    SRC_SSER  = 3'd4
  } src_e;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/ige_pending.sv
module ige_pending
  import ige_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign pend_o[g] = q;

    a_r3_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> q);
    a_r4_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr_i[g]) |=> q);
    a_r4_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !q);
    // R5: the set pulse wins over a clear in the same cycle
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[g] && clr_i[g]) |=> q);
  end
endmodule

// File: rtl/ige_enable_reg.sv
module ige_enable_reg
  import ige_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    en_o <= '0;
    else if (we_i) en_o <= d_i;
  end

  a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (en_o == $past(d_i)));
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(en_o));
endmodule

// File: rtl/ige_irq_merge.sv
module ige_irq_merge
  import ige_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N-1:0] live;
  always_comb begin
    for (int i = 0; i < N; i++) live[i] = pend_i[i] & en_i[i];
  end
  assign irq_o = |live;
endmodule

// File: rtl/ige_ctrl.sv
module ige_ctrl
  import ige_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_pulse,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_out
);
  src_vec_t pend, en, clr;

  assign clr = wr_en ? wr_data[CLR_LSB +: NSRC] : '0;

  ige_pending #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(req_pulse), .clr_i(clr), .pend_o(pend)
  );

  ige_enable_reg #(.N(NSRC)) u_en (
    .clk(clk), .rst_n(rst_n), .we_i(wr_en), .d_i(wr_data[NSRC-1:0]), .en_o(en)
  );

  ige_irq_merge #(.N(NSRC)) u_merge (
    .pend_i(pend), .en_i(en), .irq_o(irq_out)
  );

  always_comb begin
    rd_data = '0;
    rd_data[NSRC-1:0]           = en;
    rd_data[CLR_LSB +: NSRC]    = pend;
  end

  // R6: the interrupt can only rise after a write or a request pulse
  a_r6_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(wr_en) || ($past(req_pulse) != '0)));
  // R6: with no write or pulse, the interrupt holds its level
  a_r6_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && req_pulse == '0) |=> $stable(irq_out));
endmodule

// File: tb/ige_ctrl_bench.sv
module ige_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  req_pulse = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  logic [4:0] m_en = '0;
  logic [4:0] m_pend = '0;

  always #10 clk = ~clk;

  ige_ctrl u_ige_ctrl (
    .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  function automatic logic [15:0] exp_rd();
    return {3'b000, m_pend, 3'b000, m_en};
  endfunction

  function automatic logic exp_irq();
    return |(m_pend & m_en);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, apply model after the edge, check at the next negedge
  task automatic step(string req, logic [4:0] p, logic w, logic [15:0] d);
    @(negedge clk);
    req_pulse = p; wr_en = w; wr_data = d;
    @(posedge clk);
    if (w) begin
      m_pend = m_pend & ~d[12:8];
      m_en   = d[4:0];
    end
    m_pend = m_pend | p;
    @(negedge clk);
    req_pulse = '0; wr_en = 1'b0; wr_data = '0;
    chk(req, rd_data, exp_rd());
    chk(req, {15'd0, irq_out}, {15'd0, exp_irq()});
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk("R1", rd_data, 16'h0000);
    chk("R1", {15'd0, irq_out}, 16'h0000);

    // R8 pending while disabled, no irq
    step("R8", 5'b00100, 1'b0, 16'h0);
    chk("R3", rd_data, 16'h0400);
    // R8 enable later raises irq
    step("R8", 5'b0, 1'b1, 16'h0004);
    chk("R6", {15'd0, irq_out}, 16'h0001);
    // R4 clear bit at 0 keeps latch; R7 unused bits written
    step("R7", 5'b0, 1'b1, 16'hE0E4);
    chk("R7", rd_data & 16'hE0E0, 16'h0000);
    chk("R4", rd_data, 16'h0404);
    // R4 clear by writing one; R9 enable byte also replaced
    step("R9", 5'b0, 1'b1, 16'h0413);
    chk("R4", rd_data, 16'h0013);
    // R5 collision on every source
    step("R5", 5'b11111, 1'b1, 16'h1F1F);
    chk("R5", rd_data, 16'h1F1F);
    // R5 single-source collision, others cleared
    step("R5", 5'b00010, 1'b1, 16'h1F00);
    chk("R5", rd_data, 16'h0200);
    chk("R6", {15'd0, irq_out}, 16'h0000);
    // R2 enable order, each source alone
    for (int i = 0; i < 5; i++) begin
      step("R2", 5'b0, 1'b1, 16'h1F00 | (16'h1 << i));
      step("R3", 5'b1 << i, 1'b0, 16'h0);
      chk("R3", rd_data, (16'h0100 << i) | (16'h1 << i));
    end
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [4:0]  p;
      logic        w;
      logic [15:0] d;
      p = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      w = ($urandom % 3 == 0);
      d = 16'($urandom);
      step("R6", p, w, d);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule